// File: doc/BRIEF.md
# Lock-Line Reservation Unit

This block gives a processing element load-linked / store-conditional behaviour on 128-byte lines. The element issues one of three atomic commands with a byte address and a transfer size. A reserve command fetches the line and remembers its line address as the single reservation. A conditional put stores the line only if that reservation is still intact. An unconditional put always stores the line, and it breaks the reservation if it lands on the reserved line.

A snoop input reports writes by other agents. A snooped write that hits the reserved line cancels the reservation. Each command that produces an outcome leaves a status code in a one-entry status slot, which the element reads by popping it. A sticky lost-reservation event output tells the element that a held reservation has gone. This happens when a new reserve replaces it, when a conditional put fails while a reservation was held, when an unconditional put breaks it, or when a snoop cancels it.

The 128-byte data movement itself is not modelled. It is reduced to a one-cycle line-buffer strobe that carries a line-aligned address and a read/write flag.

Top module: `llr_unit`

## Requirements
- R1: After reset the status slot is empty (`stat_count`=0), `lr_event`=0, `lb_req`=0, and no reservation is held, so a conditional put then fails without raising the event.
- R2: A command whose `cmd_size` is not exactly 128 has no effect: no status, no line-buffer strobe, no event, and the reservation is unchanged.
- R3: Op code 0 (reserve) records the command's line as the reservation, strobes a line read (`lb_req`=1, `lb_we`=0), and posts status code 4.
- R4: A reserve issued while a reservation is already held sets `lr_event`.
- R5: Op code 1 (conditional put) to the reserved line while the reservation is valid strobes a line write, posts status code 0, and clears the reservation. Any byte address inside the same 128-byte line matches.
- R6: A conditional put that does not succeed posts status code 1, produces no strobe, and clears the reservation. It sets `lr_event` only if a reservation was held.
- R7: Op code 2 (unconditional put, reporting) always strobes a line write and posts status code 2. If it hits the reserved line, it sets `lr_event` and clears the reservation.
- R8: Op code 3 (unconditional put, quiet) behaves like op code 2, but it posts no status and leaves the slot untouched. A put to a different line keeps the reservation.
- R9: A snoop write (`snoop_valid`) to the reserved line invalidates the reservation and sets `lr_event`. A snoop to another line has no effect. A snoop takes effect before a command in the same cycle.
- R10: The status slot holds one entry. A new status overwrites an unread one. `stat_pop` empties the slot. A push and a pop in the same cycle leave the new code in the slot.
- R11: `lr_event` stays set until `evt_ack`. If a new event and an ack arrive in the same cycle, the event stays set.
- R12: Op codes 4 to 7 are ignored, exactly like a rejected size.
- R13: Every result (status, event, strobe) appears after the first rising clock edge following the command, and `lb_req` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 reserve, 1 conditional put, 2 unconditional put with status, 3 unconditional put without status |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_size | input | SIZE_W | Transfer size in bytes; must be 128 |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| stat_pop | input | 1 | Read (empty) the status slot |
| stat_count | output | 1 | Status slot occupancy |
| stat_code | output | 3 | Status code: 0 cond ok, 1 cond fail, 2 uncond ok, 4 reserve ok |
| evt_ack | input | 1 | Clear the lost-reservation event |
| lr_event | output | 1 | Sticky lost-reservation event |
| lb_req | output | 1 | One-cycle line-buffer strobe |
| lb_we | output | 1 | Strobe is a line write (1) or read (0) |
| lb_addr | output | ADDR_W | Line-aligned address of the strobe |

## Verification
Every output of this block is registered once. A command driven before a rising edge therefore shows its status, event and strobe exactly one edge later, and the strobe is gone one edge after that. The bench drives each stimulus on a falling edge and checks on the next falling edge, so that is one rising edge later. It then spends one idle cycle that pops the slot and acks the event, and checks that the strobe has dropped. The reservation has no port of its own, so the bench exposes it through the conditional-put outcome of the next step in the table.

// File: rtl/llr_pkg.sv
package llr_pkg;
  localparam logic [2:0] OP_RESERVE   = 3'd0;
  localparam logic [2:0] OP_PUT_COND  = 3'd1;
  localparam logic [2:0] OP_PUT_UNC_R = 3'd2;
  localparam logic [2:0] OP_PUT_UNC_Q = 3'd3;

  localparam logic [2:0] ST_COND_OK   = 3'd0;
  localparam logic [2:0] ST_COND_FAIL = 3'd1;
  localparam logic [2:0] ST_UNC_OK    = 3'd2;
  localparam logic [2:0] ST_GET_OK    = 3'd4;

  // two byte addresses fall in the same line of 2**shift bytes
  function automatic logic same_line(input logic [63:0] a, input logic [63:0] b,
                                     input int shift);
    return (a >> shift) == (b >> shift);
  endfunction

  // clears the byte offset within a line
  function automatic logic [63:0] line_base(input logic [63:0] a, input int shift);
    return (a >> shift) << shift;
  endfunction
endpackage

// File: rtl/llr_decide.sv
module llr_decide import llr_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 15,
  parameter int LINE_BYTES = 128
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              resv_valid,
  input  logic [ADDR_W-1:0] resv_addr,
  output logic              snoop_hit,
  output logic              resv_load,
  output logic              resv_drop,
  output logic              push,
  output logic [2:0]        push_code,
  output logic              evt_set,
  output logic              lb_go,
  output logic              lb_write
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  logic cmd_ok, held, cmd_hits;

  assign cmd_ok    = cmd_valid && (cmd_size == SIZE_W'(LINE_BYTES));
  assign snoop_hit = snoop_valid && resv_valid &&
                     same_line(64'(snoop_addr), 64'(resv_addr), LINE_SHIFT);
  // a snoop in the same cycle is seen before the command
  assign held      = resv_valid && !snoop_hit;
  assign cmd_hits  = held && same_line(64'(cmd_addr), 64'(resv_addr), LINE_SHIFT);

  always_comb begin
    resv_load = 1'b0;
    resv_drop = snoop_hit;
    push      = 1'b0;
    push_code = ST_COND_FAIL;
    evt_set   = snoop_hit;
    lb_go     = 1'b0;
    lb_write  = 1'b0;
    if (cmd_ok) begin
      case (cmd_op)
        OP_RESERVE: begin
          resv_load = 1'b1;
          push      = 1'b1;
          push_code = ST_GET_OK;
          lb_go     = 1'b1;
          if (held) evt_set = 1'b1;
        end
        OP_PUT_COND: begin
          push      = 1'b1;
          resv_drop = 1'b1;
          if (cmd_hits) begin
            push_code = ST_COND_OK;
            lb_go     = 1'b1;
            lb_write  = 1'b1;
          end else begin
            push_code = ST_COND_FAIL;
            if (held) evt_set = 1'b1;
          end
        end
        OP_PUT_UNC_R, OP_PUT_UNC_Q: begin
          lb_go    = 1'b1;
          lb_write = 1'b1;
          if (cmd_op == OP_PUT_UNC_R) begin
            push      = 1'b1;
            push_code = ST_UNC_OK;
          end
          if (cmd_hits) begin
            evt_set   = 1'b1;
            resv_drop = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/llr_resv.sv
module llr_resv import llr_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drop,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              valid,
  output logic [ADDR_W-1:0] line_addr
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      line_addr <= '0;
    end else if (load) begin
      valid     <= 1'b1;
      line_addr <= ADDR_W'(line_base(64'(load_addr), LINE_SHIFT));
    end else if (drop) begin
      valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/llr_stat_chan.sv
module llr_stat_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [2:0] push_code,
  input  logic       pop,
  output logic       count,
  output logic [2:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= 1'b0;
      code  <= '0;
    end else if (push) begin
      count <= 1'b1;
      code  <= push_code;
    end else if (pop) begin
      count <= 1'b0;
    end
  end
endmodule

// File: rtl/llr_event.sv
module llr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end
endmodule

// File: rtl/llr_unit.sv
module llr_unit import llr_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 15,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              stat_pop,
  output logic              stat_count,
  output logic [2:0]        stat_code,
  input  logic              evt_ack,
  output logic              lr_event,
  output logic              lb_req,
  output logic              lb_we,
  output logic [ADDR_W-1:0] lb_addr
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  // named internal events, also observed by the checker
  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic              snoop_hit, resv_load, resv_drop;
  logic              stat_push, evt_set, lb_go, lb_write;
  logic [2:0]        stat_push_code;

  llr_decide #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)) u_decide (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .resv_valid(resv_valid), .resv_addr(resv_addr),
    .snoop_hit(snoop_hit), .resv_load(resv_load), .resv_drop(resv_drop),
    .push(stat_push), .push_code(stat_push_code), .evt_set(evt_set),
    .lb_go(lb_go), .lb_write(lb_write)
  );

  llr_resv #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_resv (
    .clk(clk), .rst_n(rst_n), .load(resv_load), .drop(resv_drop),
    .load_addr(cmd_addr), .valid(resv_valid), .line_addr(resv_addr)
  );

  llr_stat_chan u_stat (
    .clk(clk), .rst_n(rst_n), .push(stat_push), .push_code(stat_push_code),
    .pop(stat_pop), .count(stat_count), .code(stat_code)
  );

  llr_event u_event (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .ack(evt_ack), .flag(lr_event)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lb_req  <= 1'b0;
      lb_we   <= 1'b0;
      lb_addr <= '0;
    end else begin
      lb_req <= lb_go;
      lb_we  <= lb_go && lb_write;
      if (lb_go) lb_addr <= ADDR_W'(line_base(64'(cmd_addr), LINE_SHIFT));
    end
  end
endmodule

// File: rtl/llr_unit_chk.sv
module llr_unit_chk import llr_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 15,
  parameter int LINE_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [SIZE_W-1:0] cmd_size,
  input logic              snoop_valid,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              stat_pop,
  input logic              stat_count,
  input logic [2:0]        stat_code,
  input logic              evt_ack,
  input logic              lr_event,
  input logic              lb_req,
  input logic              lb_we,
  input logic              resv_valid,
  input logic [ADDR_W-1:0] resv_addr
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  logic size_ok, snp_on_resv, cmd_on_resv;
  assign size_ok     = cmd_size == SIZE_W'(LINE_BYTES);
  assign snp_on_resv = snoop_valid && resv_valid &&
                       same_line(64'(snoop_addr), 64'(resv_addr), LINE_SHIFT);
  assign cmd_on_resv = resv_valid && same_line(64'(cmd_addr), 64'(resv_addr), LINE_SHIFT);

  // R2
  size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !size_ok |=> !lb_req);
  // R3
  reserve_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && size_ok && cmd_op == OP_RESERVE
    |=> stat_count && stat_code == ST_GET_OK && lb_req && !lb_we && resv_valid);
  // R5
  cond_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && size_ok && cmd_op == OP_PUT_COND && cmd_on_resv && !snp_on_resv
    |=> stat_code == ST_COND_OK && lb_we && !resv_valid);
  // R8
  quiet_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && size_ok && cmd_op == OP_PUT_UNC_Q && stat_count && !stat_pop
    |=> stat_count && $stable(stat_code) && lb_we);
  // R9
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_on_resv |=> lr_event);
  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pop && !cmd_valid |=> !stat_count);
  // R11
  event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_event && !evt_ack |=> lr_event);
  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op > OP_PUT_UNC_Q |=> !lb_req);
endmodule

bind llr_unit llr_unit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .cmd_size(cmd_size), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
  .stat_pop(stat_pop), .stat_count(stat_count), .stat_code(stat_code),
  .evt_ack(evt_ack), .lr_event(lr_event), .lb_req(lb_req), .lb_we(lb_we),
  .resv_valid(resv_valid), .resv_addr(resv_addr)
);

// File: tb/llr_unit_bench.sv
`timescale 1ns/1ps
module llr_unit_bench;
  localparam int AW = 32;
  localparam int SW = 15;
  localparam logic [SW-1:0] L = 15'd128;
  localparam int NV = 27;
  // {op, addr, size, snoop_v, snoop_addr, exp_cnt, exp_code, exp_evt, exp_req, exp_we}
  localparam logic [89:0] VEC [NV] = '{
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0}, // R3
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd0, 1'b0, 1'b1, 1'b1}, // R5
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R6 none held
    {3'd0, 32'h1000, 15'd64, 1'b0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // R2
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R2 no resv made
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd0, 32'h2000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b1, 1'b1, 1'b0}, // R4
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd1, 1'b1, 1'b0, 1'b0}, // R6 held
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd3, 32'h3000, L,      1'b0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b1, 1'b1}, // R8
    {3'd1, 32'h1040, L,      1'b0, 32'h0,    1'b1, 3'd0, 1'b0, 1'b1, 1'b1}, // R5 R8
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd2, 32'h1004, L,      1'b0, 32'h0,    1'b1, 3'd2, 1'b1, 1'b1, 1'b1}, // R7
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R7 cleared
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd7, 32'h1000, L,      1'b1, 32'h107c, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0}, // R9 R12
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R9
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd5, 32'h1000, L,      1'b1, 32'h1080, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // R9 R12
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd0, 1'b0, 1'b1, 1'b1}, // R9 kept
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd3, 32'h1010, L,      1'b0, 32'h0,    1'b0, 3'd0, 1'b1, 1'b1, 1'b1}, // R8
    {3'd1, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b0},
    {3'd0, 32'h1000, L,      1'b0, 32'h0,    1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {3'd1, 32'h1000, L,      1'b1, 32'h1020, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0}, // R9 order
    {3'd2, 32'h5000, L,      1'b0, 32'h0,    1'b1, 3'd2, 1'b0, 1'b1, 1'b1}, // R7
    {3'd1, 32'h5000, 15'd256,1'b0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0}  // R2
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [SW-1:0] cmd_size = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          stat_pop = 1'b0;
  logic          evt_ack = 1'b0;
  logic          stat_count, lr_event, lb_req, lb_we;
  logic [2:0]    stat_code;
  logic [AW-1:0] lb_addr;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  llr_unit u_llr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .stat_pop(stat_pop), .stat_count(stat_count),
    .stat_code(stat_code), .evt_ack(evt_ack), .lr_event(lr_event),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one rising edge later)
  task automatic step(input logic v, input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [SW-1:0] sz, input logic sv, input logic [AW-1:0] sa,
                      input logic pop, input logic ack);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_size = sz;
    snoop_valid = sv; snoop_addr = sa; stat_pop = pop; evt_ack = ack;
    @(negedge clk);
  endtask

  task automatic clean();
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b1, 1'b1);
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", 32'(stat_count), 0);
    check("R1 event", 32'(lr_event), 0);
    check("R1 lb_req", 32'(lb_req), 0);

    for (int i = 0; i < NV; i++) begin
      logic [89:0] v;
      v = VEC[i];
      step(1'b1, v[89:87], v[86:55], v[54:40], v[39], v[38:7], 1'b0, 1'b0);
      check($sformatf("R13 vec%0d count", i), 32'(stat_count), 32'(v[6]));
      if (v[6]) check($sformatf("R10 vec%0d code", i), 32'(stat_code), 32'(v[5:3]));
      check($sformatf("R11 vec%0d event", i), 32'(lr_event), 32'(v[2]));
      check($sformatf("R3 vec%0d lb_req", i), 32'(lb_req), 32'(v[1]));
      check($sformatf("R7 vec%0d lb_we", i), 32'(lb_we), 32'(v[0]));
      if (v[1]) check($sformatf("R13 vec%0d lb_addr", i), lb_addr, v[86:55] & 32'hFFFF_FF80);
      step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b1, 1'b1);
      check($sformatf("R13 vec%0d pulse", i), 32'(lb_req), 0);
    end
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b0);

    // R10: an unread status is overwritten
    step(1'b1, 3'd0, 32'h8000, L, 1'b0, '0, 1'b0, 1'b0);
    step(1'b1, 3'd1, 32'h9000, L, 1'b0, '0, 1'b0, 1'b0);
    check("R10 overwrite count", 32'(stat_count), 1);
    check("R10 overwrite code", 32'(stat_code), 1);
    check("R6 mismatch event", 32'(lr_event), 1);
    clean();

    // R10: push and pop in one cycle keep the new code
    step(1'b1, 3'd0, 32'h8000, L, 1'b0, '0, 1'b0, 1'b0);
    step(1'b1, 3'd1, 32'h8000, L, 1'b0, '0, 1'b1, 1'b0);
    check("R10 push+pop count", 32'(stat_count), 1);
    check("R10 push+pop code", 32'(stat_code), 0);
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
    check("R10 pop empties", 32'(stat_count), 0);
    clean();

    // R11: set wins over ack; sticky; ack clears
    step(1'b1, 3'd0, 32'hA000, L, 1'b0, '0, 1'b0, 1'b0);
    step(1'b1, 3'd0, 32'hB000, L, 1'b0, '0, 1'b0, 1'b1);
    check("R11 set over ack", 32'(lr_event), 1);
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    check("R11 sticky", 32'(lr_event), 1);
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b1);
    check("R11 ack clears", 32'(lr_event), 0);
    clean();

    // R1: reset drops a held reservation
    step(1'b1, 3'd0, 32'hC000, L, 1'b0, '0, 1'b0, 1'b0);
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset count", 32'(stat_count), 0);
    step(1'b1, 3'd1, 32'hC000, L, 1'b0, '0, 1'b0, 1'b0);
    check("R1 no resv after reset", 32'(stat_code), 1);
    check("R1 no event after reset", 32'(lr_event), 0);
    clean();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule